// File: doc/BRIEF.md
# Successive-Approximation Tuning-Word Controller

This block produces the frequency select word for a phase-accumulator synthesizer. The loop drives the synthesizer toward an unknown input frequency. A frequency comparator outside the block reports whether the synthesized frequency must rise or fall. After a start pulse the block runs a binary search on the word. The search begins at half of the maximum word with a step of one quarter of the maximum, and the step halves after every update. When an update with a step of one has been applied, the block becomes a saturating up/down counter. From then on it follows the input by moving one count per update.

Updates happen only on a settle tick from outside the block, so the comparator has time to respond to each new frequency. The maximum word is a parameter. It must be a power of two of at least 4. Its default is one quarter of the accumulator range, which keeps the output well below the Nyquist limit.

Top module: `sar_tune_ctrl`

## Requirements
- R1: During reset and after it, with no start pulse, `tune_word_o` is 0 and both `searching_o` and `tracking_o` are low.
- R2: The cycle after `start_i` is sampled high, `tune_word_o` equals MAX/2 and `searching_o` is high, whatever the previous state.
- R3: While searching, each sampled `settle_i` adds the current step to the word if `raise_i` is 1, and subtracts it if `raise_i` is 0. The first step is MAX/4.
- R4: The step halves after every search update. The update that uses a step of 1 is the last one, so there are log2(MAX)-1 updates. In the cycle after it, `searching_o` is low and `tracking_o` is high.
- R5: While tracking, each sampled `settle_i` moves the word by exactly 1 in the direction of `raise_i` (1 means up), unless the word is saturated.
- R6: The word never goes below 0 and never above MAX. In tracking it stays at MAX when pushed up and at 0 when pushed down.
- R7: A start pulse during a search or during tracking restarts the search from MAX/2 with step MAX/4.
- R8: In a cycle without `settle_i` or `start_i` the word holds. A `settle_i` while idle has no effect.
- R9: `searching_o` and `tracking_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a new measurement with a search from half scale |
| settle_i | input | 1 | One-cycle tick: the comparator result is valid, so apply one update |
| raise_i | input | 1 | Comparator direction: 1 asks for a higher frequency, 0 for a lower one |
| tune_word_o | output | WORD_W | Frequency select word for the synthesizer |
| searching_o | output | 1 | High while the binary search runs |
| tracking_o | output | 1 | High once the up/down tracking has taken over |

## Verification
On every cycle the assertions check four things:
- the two flags are never high together;
- the word stays within the maximum;
- the word holds in cycles with no tick and no start;
- the word moves by at most one per tracking tick, and a start always lands on half scale in the search phase.

The step sequence cannot be checked from the ports alone on a single cycle. The bench therefore checks it against a comparator model for every target value of a small configuration. That covers the exact path of the search, the number of updates before hand-over, and saturation at both ends during tracking.

// File: rtl/sar_tune_pkg.sv
package sar_tune_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SEARCH = 2'd1,
        PH_TRACK  = 2'd2
    } tune_phase_e;
endpackage

// File: rtl/sar_tune_sat_step.sv
// Adds or subtracts an amount, clamping the result to [0, max_val].
module sar_tune_sat_step #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] base_i,
    input  logic [WORD_W-1:0] amount_i,
    input  logic              up_i,
    input  logic [WORD_W-1:0] max_i,
    output logic [WORD_W-1:0] result_o
);
    logic [WORD_W:0] sum_wide;

    always_comb begin
        sum_wide = {1'b0, base_i} + {1'b0, amount_i};
        if (up_i) begin
            result_o = (sum_wide > {1'b0, max_i}) ? max_i : sum_wide[WORD_W-1:0];
        end else begin
            result_o = (amount_i > base_i) ? '0 : base_i - amount_i;
        end
    end
endmodule

// File: rtl/sar_tune_step_gen.sv
// Gives the next search step and marks the final search update.
module sar_tune_step_gen #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] step_i,
    output logic [WORD_W-1:0] step_next_o,
    output logic              final_o
);
    always_comb begin
        step_next_o = step_i >> 1;
        final_o     = (step_i == WORD_W'(1));
    end
endmodule

// File: rtl/sar_tune_ctrl.sv
module sar_tune_ctrl
    import sar_tune_pkg::*;
#(
    parameter int              WORD_W   = 32,
    parameter logic [WORD_W-1:0] MAX_WORD = {2'b01, {(WORD_W-2){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              settle_i,
    input  logic              raise_i,
    output logic [WORD_W-1:0] tune_word_o,
    output logic              searching_o,
    output logic              tracking_o
);
    localparam logic [WORD_W-1:0] HALF_WORD    = MAX_WORD >> 1;
    localparam logic [WORD_W-1:0] QUARTER_WORD = MAX_WORD >> 2;

    typedef struct packed {
        tune_phase_e       phase;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] step;
    } tune_state_t;

    tune_state_t st_d, st_q;

    logic [WORD_W-1:0] amount;
    logic [WORD_W-1:0] moved_word;
    logic [WORD_W-1:0] step_next;
    logic              step_final;

    assign amount = (st_q.phase == PH_TRACK) ? WORD_W'(1) : st_q.step;

    sar_tune_sat_step #(.WORD_W(WORD_W)) u_sat_step (
        .base_i   (st_q.word),
        .amount_i (amount),
        .up_i     (raise_i),
        .max_i    (MAX_WORD),
        .result_o (moved_word)
    );

    sar_tune_step_gen #(.WORD_W(WORD_W)) u_step_gen (
        .step_i      (st_q.step),
        .step_next_o (step_next),
        .final_o     (step_final)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.phase = PH_SEARCH;
            st_d.word  = HALF_WORD;
            st_d.step  = QUARTER_WORD;
        end else if (settle_i) begin
            unique case (st_q.phase)
                PH_SEARCH: begin
                    st_d.word = moved_word;
                    st_d.step = step_next;
                    if (step_final) begin
                        st_d.phase = PH_TRACK;
                    end
                end
                PH_TRACK: begin
                    st_d.word = moved_word;
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, word: '0, step: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tune_word_o = st_q.word;
    assign searching_o = (st_q.phase == PH_SEARCH);
    assign tracking_o  = (st_q.phase == PH_TRACK);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({searching_o, tracking_o}));

    assert_word_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tune_word_o <= MAX_WORD);

    assert_start_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tune_word_o == HALF_WORD) && searching_o);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !settle_i) |=> $stable(tune_word_o));

    assert_track_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking_o && settle_i && !start_i) |=>
            (tune_word_o == $past(tune_word_o)) ||
            (tune_word_o == $past(tune_word_o) + WORD_W'(1)) ||
            (tune_word_o == $past(tune_word_o) - WORD_W'(1)));
endmodule

// File: tb/sar_tune_ctrl_bench.sv
module sar_tune_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int MAXV       = 64;
    localparam int NSEARCH    = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         settle_i = 1'b0;
    logic         raise_i = 1'b0;
    logic [W-1:0] tune_word_o;
    logic         searching_o;
    logic         tracking_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_tune_ctrl #(.WORD_W(W)) u_sar_tune_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
        .raise_i(raise_i), .tune_word_o(tune_word_o),
        .searching_o(searching_o), .tracking_o(tracking_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic do_settle(input bit up);
        @(negedge clk); raise_i = up; settle_i = 1'b1;
        @(negedge clk); settle_i = 1'b0;
    endtask

    function automatic int clamp(input int v);
        if (v < 0) return 0;
        if (v > MAXV) return MAXV;
        return v;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int w;
        int s;
        bit up;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 word", int'(tune_word_o), 0);
        check("R1 flags", int'({searching_o, tracking_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 settle while idle ignored
        do_settle(1'b1);
        check("R8 idle settle", int'(tune_word_o), 0);
        check("R1 flags after reset", int'({searching_o, tracking_o}), 0);

        // Sweep every target with a comparator model
        for (int tgt = 0; tgt <= MAXV; tgt++) begin
            do_start();
            check("R2 half", int'(tune_word_o), MAXV/2);
            check("R2 searching", int'(searching_o), 1);
            w = MAXV/2; s = MAXV/4;
            for (int k = 0; k < NSEARCH; k++) begin
                up = (w < tgt);
                do_settle(up);
                w = clamp(up ? w + s : w - s);
                s = s / 2;
                check("R3 search word", int'(tune_word_o), w);
                check(k == NSEARCH-1 ? "R4 handover" : "R4 still searching",
                      int'({searching_o, tracking_o}), k == NSEARCH-1 ? 1 : 2);
            end
            for (int k = 0; k < 3; k++) begin
                up = (w < tgt);
                do_settle(up);
                w = clamp(up ? w + 1 : w - 1);
                check("R5 track word", int'(tune_word_o), w);
            end
        end

        // R6 saturation at top
        do_start();
        w = MAXV/2; s = MAXV/4;
        for (int k = 0; k < NSEARCH; k++) begin
            do_settle(1'b1); w = w + s; s = s / 2;
        end
        check("R4 max search end", int'(tune_word_o), MAXV-1);
        for (int k = 0; k < 4; k++) begin
            do_settle(1'b1);
            check("R6 top saturation", int'(tune_word_o), MAXV);
        end
        // R8 hold without settle
        repeat (5) @(negedge clk);
        check("R8 hold", int'(tune_word_o), MAXV);
        // R6 saturation at bottom
        w = MAXV;
        for (int k = 0; k < MAXV + 6; k++) begin
            do_settle(1'b0); w = clamp(w - 1);
            check("R6 bottom track", int'(tune_word_o), w);
        end
        check("R6 bottom", int'(tune_word_o), 0);
        check("R9 tracking only", int'({searching_o, tracking_o}), 1);

        // R7 restart during tracking
        do_start();
        check("R7 restart from track", int'(tune_word_o), MAXV/2);
        check("R7 searching", int'({searching_o, tracking_o}), 2);
        // R7 restart during search, then confirm fresh step MAX/4
        do_settle(1'b0);
        do_settle(1'b0);
        check("R3 two downs", int'(tune_word_o), MAXV/2 - MAXV/4 - MAXV/8);
        do_start();
        check("R7 restart from search", int'(tune_word_o), MAXV/2);
        do_settle(1'b1);
        check("R7 fresh step", int'(tune_word_o), MAXV/2 + MAXV/4);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule